// File: doc/BRIEF.md
# Load-Use Stall and Flush Controller

This block is the hazard-detection piece of a five-stage in-order pipeline. It watches the two source register numbers of the instruction sitting in decode. It also watches the instruction in execute: whether that instruction reads memory, and which register it writes. From these it decides, within the same cycle, whether the decode instruction must wait one cycle for a loaded value. The controller does not hold the pipeline registers itself. It only drives their enables, so that the pipeline around it stalls or flushes.

On a load-use dependency, the controller lowers the write enables of the program counter and the fetch/decode register. The decode instruction and the instruction behind it then stay where they are. The controller also raises a bubble select, which zeroes the control fields entering the decode/execute register, so an empty slot moves down the pipe. One cycle later the load has reached the memory stage and execute holds the bubble. The dependency then no longer matches and the pipeline moves again, so exactly one bubble is inserted. A taken-branch request kills the instruction already fetched: the fetch/decode register is overwritten with zeros, which is the no-op encoding. All outputs are plain level signals, with no handshake, because no data passes through this block.

Top module: `load_use_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc_we` and `ifid_we` are 0, `idex_bubble` is 1 and `ifid_flush` is 0.
- R2: When `ex_mem_read` is 1, `ex_dest` is non-zero and `ex_dest` equals `id_src_a`, the outputs in the same cycle are `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1, provided `branch_flush` is 0.
- R3: The same stall as in R2 occurs when `ex_dest` equals `id_src_b` instead of `id_src_a`.
- R4: When `ex_dest` is 0 (register zero), no stall occurs, even if `ex_mem_read` is 1 and a source field is 0.
- R5: When `ex_mem_read` is 0, no stall occurs, even if `ex_dest` matches a source field.
- R6: Out of reset, with no hazard and no flush, `pc_we`=1, `ifid_we`=1, `idex_bubble`=0 and `ifid_flush`=0.
- R7: When `branch_flush` is 1 and there is no hazard, `ifid_flush`=1, `ifid_we`=1, `pc_we`=1 and `idex_bubble`=0.
- R8: When `branch_flush` and a load-use hazard are both present, the flush wins for fetch/decode and the PC (`ifid_flush`=1, `ifid_we`=1, `pc_we`=1), while `idex_bubble` is still 1.
- R9: The outputs depend only on the current inputs. After one stall cycle, once execute holds the bubble (`ex_mem_read`=0, `ex_dest`=0), the same decode instruction proceeds, so exactly one bubble is inserted per load-use pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the embedded checks |
| rst_n | input | 1 | Active-low reset; forces the quiet output state |
| id_src_a | input | 5 | First source register field of the decode instruction |
| id_src_b | input | 5 | Second source register field of the decode instruction |
| ex_mem_read | input | 1 | Execute-stage instruction reads memory |
| ex_dest | input | 5 | Execute-stage destination register number |
| branch_flush | input | 1 | Taken-branch request to kill the fetched instruction |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields written into decode/execute |
| ifid_flush | output | 1 | Load all zeros into fetch/decode at the next edge |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus. No register sits on the path. The bench changes the inputs shortly after a falling edge and samples the outputs one nanosecond later, well before the next rising edge. No check depends on the order of events at an edge. For the one-bubble sequence in R9, the bench steps the inputs across a rising edge to mimic the load moving from execute to memory. It then checks the stall in the first cycle and the release in the second.

// File: rtl/lus_pkg.sv
package lus_pkg;
  localparam int unsigned REG_W = 5;
  localparam int unsigned N_SRC = 2;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic bubble;
    logic ifid_flush;
  } lus_ctl_t;

  localparam lus_ctl_t CTL_QUIET = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1, ifid_flush: 1'b0};
endpackage

// File: rtl/lus_match.sv
module lus_match #(
  parameter int unsigned RW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC*RW-1:0] srcs,
  input  logic [RW-1:0]      dest,
  output logic [NSRC-1:0]    hit
);
  logic dest_live;
  assign dest_live = (dest != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit[g] = dest_live && (srcs[g*RW +: RW] == dest);
  end
endmodule

// File: rtl/lus_detect.sv
module lus_detect #(
  parameter int unsigned RW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC*RW-1:0] srcs,
  input  logic [RW-1:0]      dest,
  input  logic               mem_read,
  output logic               load_use
);
  logic [NSRC-1:0] hit;

  lus_match #(.RW(RW), .NSRC(NSRC)) u_match (
    .srcs (srcs),
    .dest (dest),
    .hit  (hit)
  );

  assign load_use = mem_read && (|hit);
endmodule

// File: rtl/lus_arbiter.sv
module lus_arbiter
  import lus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_use,
  input  logic     flush_req,
  output lus_ctl_t ctl
);
  always_comb begin
    if (!rst_n) begin
      ctl = CTL_QUIET;
    end else begin
      ctl.bubble     = load_use;
      ctl.ifid_flush = flush_req;
      ctl.pc_we      = flush_req | ~load_use;
      ctl.ifid_we    = flush_req | ~load_use;
    end
  end

  // R8: flush priority never removes the bubble
  a_r8_bubble_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && load_use) |-> (ctl.bubble && ctl.ifid_flush && ctl.pc_we));

  // R7: a flush always lets fetch/decode take the zero word
  a_r7_flush_writes: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (ctl.ifid_we && ctl.ifid_flush));
endmodule

// File: rtl/load_use_stall_ctrl.sv
module load_use_stall_ctrl
  import lus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             ex_mem_read,
  input  logic [REG_W-1:0] ex_dest,
  input  logic             branch_flush,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble,
  output logic             ifid_flush
);
  logic [N_SRC*REG_W-1:0] srcs;
  logic                   load_use;
  lus_ctl_t               ctl;

  assign srcs = {id_src_b, id_src_a};

  lus_detect #(.RW(REG_W), .NSRC(N_SRC)) u_detect (
    .srcs     (srcs),
    .dest     (ex_dest),
    .mem_read (ex_mem_read),
    .load_use (load_use)
  );

  lus_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_use  (load_use),
    .flush_req (branch_flush),
    .ctl       (ctl)
  );

  assign pc_we       = ctl.pc_we;
  assign ifid_we     = ctl.ifid_we;
  assign idex_bubble = ctl.bubble;
  assign ifid_flush  = ctl.ifid_flush;

  // R1: quiet outputs throughout reset
  always_comb begin
    if (rst_n === 1'b0) begin
      a_r1_reset_quiet: assert (!pc_we && !ifid_we && idex_bubble && !ifid_flush);
    end
  end

  // R2 / R3: a matching load stalls fetch and decode
  a_r2_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && ex_dest != '0 && !branch_flush &&
     (ex_dest == id_src_a || ex_dest == id_src_b))
    |-> (!pc_we && !ifid_we && idex_bubble));

  // R4: register zero never causes a stall
  a_r4_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dest == '0) |-> !idex_bubble);

  // R5: without a memory read there is no bubble
  a_r5_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_read |-> !idex_bubble);

  // R6: a quiet pipeline advances every cycle
  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_mem_read && !branch_flush) |-> (pc_we && ifid_we && !ifid_flush));
endmodule

// File: tb/load_use_stall_ctrl_bench.sv
module load_use_stall_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_src_a = '0;
  logic [4:0] id_src_b = '0;
  logic       ex_mem_read = 1'b0;
  logic [4:0] ex_dest = '0;
  logic       branch_flush = 1'b0;
  logic       pc_we, ifid_we, idex_bubble, ifid_flush;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  load_use_stall_ctrl u_load_use_stall_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_src_a     (id_src_a),
    .id_src_b     (id_src_b),
    .ex_mem_read  (ex_mem_read),
    .ex_dest      (ex_dest),
    .branch_flush (branch_flush),
    .pc_we        (pc_we),
    .ifid_we      (ifid_we),
    .idex_bubble  (idex_bubble),
    .ifid_flush   (ifid_flush)
  );

  // expected order: {pc_we, ifid_we, idex_bubble, ifid_flush}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_we, ifid_we, idex_bubble, ifid_flush};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic [4:0] b,
                       input logic rd, input logic [4:0] d, input logic fl);
    @(negedge clk);
    id_src_a = a; id_src_b = b; ex_mem_read = rd; ex_dest = d; branch_flush = fl;
    #1;
  endtask

  task automatic t_reset;
    drive(5'd3, 5'd4, 1'b1, 5'd3, 1'b1);
    chk("R1 reset with hazard and flush", 4'b0010);
    drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R1 reset idle", 4'b0010);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_free_run;
    drive(5'd1, 5'd2, 1'b0, 5'd0, 1'b0);
    chk("R6 idle advance", 4'b1100);
    drive(5'd7, 5'd9, 1'b1, 5'd10, 1'b0);
    chk("R6 load without match", 4'b1100);
  endtask

  task automatic t_src_a;
    drive(5'd8, 5'd2, 1'b1, 5'd8, 1'b0);
    chk("R2 match on first source", 4'b0010);
    drive(5'd31, 5'd0, 1'b1, 5'd31, 1'b0);
    chk("R2 match on register 31", 4'b0010);
  endtask

  task automatic t_src_b;
    drive(5'd1, 5'd17, 1'b1, 5'd17, 1'b0);
    chk("R3 match on second source", 4'b0010);
    drive(5'd5, 5'd5, 1'b1, 5'd5, 1'b0);
    chk("R3 match on both sources", 4'b0010);
  endtask

  task automatic t_zero_dest;
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b0);
    chk("R4 load to register zero", 4'b1100);
  endtask

  task automatic t_no_read;
    drive(5'd12, 5'd12, 1'b0, 5'd12, 1'b0);
    chk("R5 match without memory read", 4'b1100);
  endtask

  task automatic t_flush;
    drive(5'd1, 5'd2, 1'b0, 5'd3, 1'b1);
    chk("R7 flush alone", 4'b1101);
  endtask

  task automatic t_flush_stall;
    drive(5'd6, 5'd2, 1'b1, 5'd6, 1'b1);
    chk("R8 flush with hazard", 4'b1111);
  endtask

  task automatic t_one_bubble;
    // cycle 1: load r9 in execute, consumer of r9 in decode
    drive(5'd4, 5'd9, 1'b1, 5'd9, 1'b0);
    chk("R9 first cycle stalls", 4'b0010);
    // cycle 2: load in memory, bubble in execute, same consumer held in decode
    drive(5'd4, 5'd9, 1'b0, 5'd0, 1'b0);
    chk("R9 second cycle releases", 4'b1100);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_src_a();
    t_src_b();
    t_zero_dest();
    t_no_read();
    t_flush();
    t_flush_stall();
    t_one_bubble();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule